// File: doc/BRIEF.md
# Partitioned Host/CPU Shared Byte Memory

This block holds a small byte memory that two agents share: a local CPU port with full access, and a byte-wide host port that a serial slave front end (SPI or I2C) would drive. Three block-granular boundaries (8 bytes per block) divide the memory into four regions. Bytes below the read-only base form the direct region, open to both sides. Bytes from the read-only base up to the FIFO base are readable by the host but cannot be written by it. Bytes from the FIFO base up to the RAM base back a byte FIFO. Everything from the RAM base upward belongs to the CPU alone.

The CPU fills the FIFO with a push strobe. The host drains it by reading one reserved bus address, 0x7F. Sticky event flags record a fall of the FIFO level below a programmed threshold, a dropped push, a read from an empty FIFO, and an illegal host access. A 32-bit vector of access flags records which host addresses were written. Each flag set clears by writing 1 to it. The interrupt output is high when any flag is set together with its enable bit.

Top module: `shm_partition_mem`

## Requirements
- R1: In the direct region (host address below the read-only base), host and CPU writes both store. Either side reads back the stored byte on its read-data output one cycle after its read strobe.
- R2: A host write at or above the read-only base and below the FIFO base is dropped and sets the access-error flag (evt_sts bit 3). The CPU can write those bytes, and the host reads them normally.
- R3: Host addresses from the FIFO base up to 0x7E cover the FIFO backing bytes and the CPU-only region. A host write there is dropped and a host read returns 0x00. Either one sets evt_sts bit 3. CPU access is unaffected.
- R4: A CPU push stores a byte at the FIFO write position. A host read of address 0x7F returns the oldest byte and removes it. Both positions wrap from RAM base − 1 back to the FIFO base, and fifo_level gives the current count.
- R5: A push into a full FIFO (fifo_level equal to RAM base − FIFO base) is dropped, leaves the level unchanged and sets the overflow flag (evt_sts bit 1).
- R6: A host read of 0x7F while the FIFO is empty returns 0x00 and sets the underflow flag (evt_sts bit 2).
- R7: The threshold flag (evt_sts bit 0) is set in the cycle the FIFO level moves from at least cfg_thresh to below it. Pushes never set it.
- R8: An accepted host write to address 0x00–0x0F sets acc_sts bit 31 minus the address. An accepted write to 0x10–0x4F sets bit 15 minus ((address − 0x10) / 4). Dropped writes and other addresses set no access bit.
- R9: Status flags stay set until a 1 is written to the matching clear bit. irq is high exactly when (evt_sts & evt_en) or (acc_sts & acc_en) is non-zero.
- R10: After reset all flags are 0, the FIFO is empty, both read-data outputs are 0x00 and irq is low.
- R11: When the CPU and the host write the same byte in the same cycle, the CPU's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ro_blk | input | 4 | Read-only region base, in 8-byte blocks |
| cfg_fifo_blk | input | 4 | FIFO region base, in 8-byte blocks |
| cfg_ram_blk | input | 6 | CPU-only region base, in 8-byte blocks (0 to 32) |
| cfg_thresh | input | 9 | FIFO level threshold |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_addr | input | 8 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle after cpu_re |
| cpu_push | input | 1 | CPU FIFO push strobe |
| cpu_push_data | input | 8 | Byte to push |
| fifo_level | output | 9 | Bytes held in the FIFO |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 7 | Host bus address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after host_re |
| evt_en | input | 4 | Event flag enables |
| evt_clr | input | 4 | Event flag clear, write 1 |
| evt_sts | output | 4 | Event flags: 0 threshold, 1 overflow, 2 underflow, 3 access error |
| acc_en | input | 32 | Access flag enables |
| acc_clr | input | 32 | Access flag clear, write 1 |
| acc_sts | output | 32 | Host write access flags |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check that the FIFO level never exceeds the configured region size, that a push into a full FIFO leaves the level unchanged and raises overflow, and that an empty-FIFO read returns zero with underflow. They also check that a host write into the read-only region raises the error flag, that flags never fall without a clear, that each host write sets at most one new access bit, and that irq stays low with all enables off. Only the bench scenarios can show the data path: ordered FIFO contents across pointer wrap, the exact threshold crossing point, the access bit mapping, and CPU-over-host priority on a shared byte.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [1:0] {
    HC_DIRECT  = 2'd0,
    HC_RDONLY  = 2'd1,
    HC_PORT    = 2'd2,
    HC_BLOCKED = 2'd3
  } host_cls_e;

  localparam int EV_THR = 0;
  localparam int EV_OVF = 1;
  localparam int EV_UDF = 2;
  localparam int EV_ERR = 3;
  localparam int EV_N   = 4;
endpackage

// File: rtl/shm_host_dec.sv
module shm_host_dec
  import shm_pkg::*;
#(
  parameter int HOST_AW = 7,
  parameter int ADDR_W  = 8,
  localparam int CW     = ADDR_W + 1
) (
  input  logic [HOST_AW-1:0] addr,
  input  logic [CW-1:0]      ro_base,
  input  logic [CW-1:0]      fifo_base,
  output host_cls_e          cls
);
  localparam logic [HOST_AW-1:0] PORT_ADDR = {HOST_AW{1'b1}};

  logic [CW-1:0] addr_x;

  always_comb begin
    addr_x = CW'(addr);
    if (addr == PORT_ADDR)       cls = HC_PORT;
    else if (addr_x >= fifo_base) cls = HC_BLOCKED;
    else if (addr_x >= ro_base)   cls = HC_RDONLY;
    else                          cls = HC_DIRECT;
  end
endmodule

// File: rtl/shm_acc_map.sv
module shm_acc_map #(
  parameter int HOST_AW  = 7,
  parameter int ACC_BITS = 32,
  parameter int SINGLE   = 16
) (
  input  logic [HOST_AW-1:0]  addr,
  output logic [ACC_BITS-1:0] hit
);
  for (genvar i = 0; i < ACC_BITS; i++) begin : g_bit
    if (i < SINGLE) begin : g_single
      assign hit[ACC_BITS-1-i] = (addr == HOST_AW'(i));
    end else begin : g_group
      localparam int GRP = i - SINGLE + SINGLE / 4;
      assign hit[ACC_BITS-1-i] = (addr[HOST_AW-1:2] == (HOST_AW-2)'(GRP));
    end
  end
endmodule

// File: rtl/shm_fifo_ctl.sv
module shm_fifo_ctl #(
  parameter int ADDR_W = 8,
  localparam int CW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     fifo_base,
  input  logic [CW-1:0]     ram_base,
  input  logic [CW-1:0]     thresh,
  input  logic              push_req,
  input  logic              pop_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]     level,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              ovf_evt,
  output logic              udf_evt,
  output logic              thr_evt
);
  logic [CW-1:0] size;
  logic [CW-1:0] wr_off, wr_nxt;
  logic [CW-1:0] rd_off, rd_nxt;
  logic [CW-1:0] level_nxt;

  always_comb begin
    size    = ram_base - fifo_base;
    push_ok = push_req && (level < size);
    pop_ok  = pop_req && (level != '0);
    ovf_evt = push_req && !push_ok;
    udf_evt = pop_req && !pop_ok;

    level_nxt = level;
    if (push_ok && !pop_ok)      level_nxt = level + CW'(1);
    else if (pop_ok && !push_ok) level_nxt = level - CW'(1);

    wr_nxt = wr_off;
    if (push_ok) wr_nxt = (wr_off + CW'(1) == size) ? '0 : wr_off + CW'(1);
    rd_nxt = rd_off;
    if (pop_ok)  rd_nxt = (rd_off + CW'(1) == size) ? '0 : rd_off + CW'(1);

    thr_evt = (level >= thresh) && (level_nxt < thresh);
    wr_addr = ADDR_W'(fifo_base + wr_off);
    rd_addr = ADDR_W'(fifo_base + rd_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off <= '0;
      rd_off <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_off <= wr_nxt;
      if (pop_ok)  rd_off <= rd_nxt;
      if (push_ok != pop_ok) level <= level_nxt;
    end
  end
endmodule

// File: rtl/shm_partition_mem.sv
module shm_partition_mem
  import shm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int HOST_AW  = 7,
  parameter int DATA_W   = 8,
  parameter int BLK_SH   = 3,
  parameter int ACC_BITS = 32,
  parameter int ACC_SGL  = 16,
  localparam int DEPTH   = 1 << ADDR_W,
  localparam int CW      = ADDR_W + 1,
  localparam int RO_BW   = HOST_AW - BLK_SH,
  localparam int RAM_BW  = CW - BLK_SH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RO_BW-1:0]    cfg_ro_blk,
  input  logic [RO_BW-1:0]    cfg_fifo_blk,
  input  logic [RAM_BW-1:0]   cfg_ram_blk,
  input  logic [CW-1:0]       cfg_thresh,
  input  logic                cpu_we,
  input  logic                cpu_re,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  input  logic                cpu_push,
  input  logic [DATA_W-1:0]   cpu_push_data,
  output logic [CW-1:0]       fifo_level,
  input  logic                host_we,
  input  logic                host_re,
  input  logic [HOST_AW-1:0]  host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  input  logic [EV_N-1:0]     evt_en,
  input  logic [EV_N-1:0]     evt_clr,
  output logic [EV_N-1:0]     evt_sts,
  input  logic [ACC_BITS-1:0] acc_en,
  input  logic [ACC_BITS-1:0] acc_clr,
  output logic [ACC_BITS-1:0] acc_sts,
  output logic                irq
);
  // reset synchronizer: asserts at once, releases on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [CW-1:0] ro_base, fifo_base, ram_base;
  assign ro_base   = CW'({cfg_ro_blk,   {BLK_SH{1'b0}}});
  assign fifo_base = CW'({cfg_fifo_blk, {BLK_SH{1'b0}}});
  assign ram_base  = CW'({cfg_ram_blk,  {BLK_SH{1'b0}}});

  host_cls_e cls;
  shm_host_dec #(.HOST_AW(HOST_AW), .ADDR_W(ADDR_W)) u_dec (
    .addr(host_addr), .ro_base(ro_base), .fifo_base(fifo_base), .cls(cls)
  );

  logic [ACC_BITS-1:0] acc_hit;
  shm_acc_map #(.HOST_AW(HOST_AW), .ACC_BITS(ACC_BITS), .SINGLE(ACC_SGL)) u_acc (
    .addr(host_addr), .hit(acc_hit)
  );

  logic host_wr_ok, host_err, pop_req;
  assign host_wr_ok = host_we && (cls == HC_DIRECT);
  assign host_err   = (host_we && (cls != HC_DIRECT)) || (host_re && (cls == HC_BLOCKED));
  assign pop_req    = host_re && (cls == HC_PORT);

  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic push_ok, pop_ok, ovf_evt, udf_evt, thr_evt;
  shm_fifo_ctl #(.ADDR_W(ADDR_W)) u_fifo (
    .clk(clk), .rst_n(rst_q),
    .fifo_base(fifo_base), .ram_base(ram_base), .thresh(cfg_thresh),
    .push_req(cpu_push), .pop_req(pop_req),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .level(fifo_level),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .ovf_evt(ovf_evt), .udf_evt(udf_evt), .thr_evt(thr_evt)
  );

  // byte storage: CPU write beats FIFO push beats host write
  logic [DATA_W-1:0] mem_rd [DEPTH];
  logic [ADDR_W-1:0] host_idx;
  assign host_idx = ADDR_W'(host_addr);

  for (genvar j = 0; j < DEPTH; j++) begin : g_byte
    logic [DATA_W-1:0] byte_q, byte_nxt;
    logic cpu_hit, push_hit, host_hit, byte_en;
    always_comb begin
      cpu_hit  = cpu_we && (cpu_addr == ADDR_W'(j));
      push_hit = push_ok && (wr_addr == ADDR_W'(j));
      host_hit = host_wr_ok && (host_idx == ADDR_W'(j));
      byte_en  = cpu_hit || push_hit || host_hit;
      if (cpu_hit)       byte_nxt = cpu_wdata;
      else if (push_hit) byte_nxt = cpu_push_data;
      else               byte_nxt = host_wdata;
    end
    always_ff @(posedge clk) begin
      if (byte_en) byte_q <= byte_nxt;
    end
    assign mem_rd[j] = byte_q;
  end

  logic [DATA_W-1:0] host_rd_nxt;
  always_comb begin
    case (cls)
      HC_DIRECT, HC_RDONLY: host_rd_nxt = mem_rd[host_idx];
      HC_PORT:              host_rd_nxt = pop_ok ? mem_rd[rd_addr] : '0;
      default:              host_rd_nxt = '0;
    endcase
  end

  logic [EV_N-1:0]     evt_set, evt_nxt;
  logic [ACC_BITS-1:0] acc_nxt;
  always_comb begin
    evt_set         = '0;
    evt_set[EV_THR] = thr_evt;
    evt_set[EV_OVF] = ovf_evt;
    evt_set[EV_UDF] = udf_evt;
    evt_set[EV_ERR] = host_err;
    evt_nxt = (evt_sts & ~evt_clr) | evt_set;
    acc_nxt = (acc_sts & ~acc_clr) | (host_wr_ok ? acc_hit : '0);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      evt_sts    <= '0;
      acc_sts    <= '0;
      cpu_rdata  <= '0;
      host_rdata <= '0;
    end else begin
      evt_sts <= evt_nxt;
      acc_sts <= acc_nxt;
      if (cpu_re)  cpu_rdata  <= mem_rd[cpu_addr];
      if (host_re) host_rdata <= host_rd_nxt;
    end
  end

  assign irq = (|(evt_sts & evt_en)) || (|(acc_sts & acc_en));
endmodule

// File: rtl/shm_chk.sv
module shm_chk #(
  parameter int ADDR_W   = 8,
  parameter int HOST_AW  = 7,
  parameter int DATA_W   = 8,
  parameter int ACC_BITS = 32,
  localparam int CW      = ADDR_W + 1
) (
  input logic                clk,
  input logic                rst_q,
  input logic                host_we,
  input logic                host_re,
  input logic [HOST_AW-1:0]  host_addr,
  input logic [DATA_W-1:0]   host_rdata,
  input logic                cpu_push,
  input logic [CW-1:0]       fifo_level,
  input logic [CW-1:0]       ro_base,
  input logic [CW-1:0]       fifo_base,
  input logic [CW-1:0]       ram_base,
  input logic [3:0]          evt_sts,
  input logic [3:0]          evt_clr,
  input logic [3:0]          evt_en,
  input logic [ACC_BITS-1:0] acc_sts,
  input logic [ACC_BITS-1:0] acc_clr,
  input logic [ACC_BITS-1:0] acc_en,
  input logic                irq
);
  localparam logic [HOST_AW-1:0] PORT_ADDR = {HOST_AW{1'b1}};

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_q)
    fifo_level <= (ram_base - fifo_base));

  // R5
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_push && fifo_level == (ram_base - fifo_base) &&
     !(host_re && host_addr == PORT_ADDR))
    |=> (evt_sts[1] && fifo_level == $past(fifo_level)));

  // R6
  udf_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (host_re && host_addr == PORT_ADDR && fifo_level == '0)
    |=> (evt_sts[2] && host_rdata == '0));

  // R2
  ro_write_err_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (host_we && CW'(host_addr) >= ro_base && CW'(host_addr) < fifo_base)
    |=> evt_sts[3]);

  // R9
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(evt_sts) & ~$past(evt_clr) & ~evt_sts) == '0);

  // R9
  acc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(acc_sts) & ~$past(acc_clr) & ~acc_sts) == '0);

  // R8
  acc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(acc_sts & ~$past(acc_sts)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (evt_en == '0 && acc_en == '0) |-> !irq);
endmodule

bind shm_partition_mem shm_chk #(
  .ADDR_W(ADDR_W), .HOST_AW(HOST_AW), .DATA_W(DATA_W), .ACC_BITS(ACC_BITS)
) u_chk (
  .clk(clk), .rst_q(rst_q), .host_we(host_we), .host_re(host_re),
  .host_addr(host_addr), .host_rdata(host_rdata), .cpu_push(cpu_push),
  .fifo_level(fifo_level), .ro_base(ro_base), .fifo_base(fifo_base),
  .ram_base(ram_base), .evt_sts(evt_sts), .evt_clr(evt_clr), .evt_en(evt_en),
  .acc_sts(acc_sts), .acc_clr(acc_clr), .acc_en(acc_en), .irq(irq)
);

// File: tb/tb_shm_partition_mem.sv
module tb_shm_partition_mem;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [3:0]  cfg_ro_blk, cfg_fifo_blk;
  logic [5:0]  cfg_ram_blk;
  logic [8:0]  cfg_thresh;
  logic        cpu_we, cpu_re, cpu_push;
  logic [7:0]  cpu_addr, cpu_wdata, cpu_push_data, cpu_rdata;
  logic [8:0]  fifo_level;
  logic        host_we, host_re;
  logic [6:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic [3:0]  evt_en, evt_clr, evt_sts;
  logic [31:0] acc_en, acc_clr, acc_sts;
  logic        irq;

  shm_partition_mem dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_ro_blk(cfg_ro_blk), .cfg_fifo_blk(cfg_fifo_blk),
    .cfg_ram_blk(cfg_ram_blk), .cfg_thresh(cfg_thresh),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_push(cpu_push), .cpu_push_data(cpu_push_data), .fifo_level(fifo_level),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_en(evt_en), .evt_clr(evt_clr), .evt_sts(evt_sts),
    .acc_en(acc_en), .acc_clr(acc_clr), .acc_sts(acc_sts), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check_eq(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic host_write(logic [6:0] a, logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    cyc();
    host_we = 1'b0;
  endtask

  // driver: queue the expected byte, then issue the read
  task automatic host_read(logic [6:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    host_re = 1'b1; host_addr = a;
    cyc();
    host_re = 1'b0;
  endtask

  task automatic cpu_write(logic [7:0] a, logic [7:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    cyc();
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(logic [7:0] a, logic [7:0] e, string tag);
    cpu_re = 1'b1; cpu_addr = a;
    cyc();
    cpu_re = 1'b0;
    check_eq(tag, cpu_rdata, e);
  endtask

  task automatic push(logic [7:0] d);
    cpu_push = 1'b1; cpu_push_data = d;
    cyc();
    cpu_push = 1'b0;
  endtask

  task automatic clear_all();
    evt_clr = 4'hF; acc_clr = '1;
    cyc();
    evt_clr = '0; acc_clr = '0;
  endtask

  // monitor: compares host read data one cycle after each strobe
  initial begin
    forever begin
      @(posedge clk);
      if (host_re) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check_eq("R1 unexpected host read", host_rdata, 0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string      t = tag_q.pop_front();
          check_eq(t, host_rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    check_eq("scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_ro_blk = 4'd4;    // 0x20
    cfg_fifo_blk = 4'd8;  // 0x40
    cfg_ram_blk = 6'd10;  // 0x50, FIFO holds 16 bytes
    cfg_thresh = 9'd4;
    cpu_we = 0; cpu_re = 0; cpu_push = 0; cpu_addr = 0; cpu_wdata = 0; cpu_push_data = 0;
    host_we = 0; host_re = 0; host_addr = 0; host_wdata = 0;
    evt_en = 0; evt_clr = 0; acc_en = 0; acc_clr = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R10 reset state
    check_eq("R10 evt_sts", evt_sts, 0);
    check_eq("R10 acc_sts", acc_sts, 0);
    check_eq("R10 fifo_level", fifo_level, 0);
    check_eq("R10 host_rdata", host_rdata, 0);
    check_eq("R10 cpu_rdata", cpu_rdata, 0);
    check_eq("R10 irq", irq, 0);

    // R1 direct region, both directions
    host_write(7'h05, 8'hA5);
    host_read(7'h05, 8'hA5, "R1 host rd host wr");
    cpu_read(8'h05, 8'hA5, "R1 cpu rd host wr");
    cpu_write(8'h06, 8'h3C);
    host_read(7'h06, 8'h3C, "R1 host rd cpu wr");

    // R8 access flag mapping
    host_write(7'h13, 8'h01);
    host_write(7'h1F, 8'h02);
    host_write(7'h0F, 8'h03);
    check_eq("R8 acc_sts map", acc_sts,
             (32'h1 << 26) | (32'h1 << 15) | (32'h1 << 12) | (32'h1 << 16));
    check_eq("R1 no error flag", evt_sts, 0);
    clear_all();
    check_eq("R9 clear acc", acc_sts, 0);

    // R2 read-only region
    cpu_write(8'h22, 8'h77);
    host_write(7'h22, 8'h11);
    check_eq("R2 err flag", evt_sts, 4'b1000);
    check_eq("R8 dropped write sets no acc", acc_sts, 0);
    host_read(7'h22, 8'h77, "R2 host reads ro byte");

    // R9 sticky, enable, clear
    repeat (5) cyc();
    check_eq("R9 sticky", evt_sts, 4'b1000);
    check_eq("R9 irq masked", irq, 0);
    evt_en = 4'b1000;
    cyc();
    check_eq("R9 irq enabled", irq, 1);
    clear_all();
    check_eq("R9 cleared", evt_sts, 0);
    check_eq("R9 irq after clear", irq, 0);
    evt_en = 0;

    // R3 blocked host addresses
    cpu_write(8'h60, 8'h99);
    host_write(7'h60, 8'h12);
    check_eq("R3 write err", evt_sts, 4'b1000);
    cpu_read(8'h60, 8'h99, "R3 cpu byte kept");
    clear_all();
    cpu_write(8'h44, 8'h5A);
    host_read(7'h44, 8'h00, "R3 host rd fifo backing");
    check_eq("R3 read err", evt_sts, 4'b1000);
    clear_all();

    // R11 same-byte collision
    cpu_we = 1'b1; cpu_addr = 8'h08; cpu_wdata = 8'hC1;
    host_we = 1'b1; host_addr = 7'h08; host_wdata = 8'hD2;
    cyc();
    cpu_we = 0; host_we = 0;
    host_read(7'h08, 8'hC1, "R11 cpu wins");
    clear_all();

    // R4/R5 fill
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
    check_eq("R4 level full", fifo_level, 16);
    check_eq("R5 no ovf yet", evt_sts[1], 0);
    push(8'hEE);
    check_eq("R5 ovf flag", evt_sts[1], 1);
    check_eq("R5 level held", fifo_level, 16);
    // R4/R7 drain
    for (int i = 0; i < 16; i++) begin
      host_read(7'h7F, 8'h10 + 8'(i), "R4 fifo order");
      if (i == 11) check_eq("R7 no thr at level 4", evt_sts[0], 0);
      if (i == 12) check_eq("R7 thr at level 3", evt_sts[0], 1);
    end
    check_eq("R4 level empty", fifo_level, 0);
    clear_all();

    // R6 underflow
    host_read(7'h7F, 8'h00, "R6 empty read");
    check_eq("R6 udf flag", evt_sts[2], 1);
    check_eq("R7 no thr on empty read", evt_sts[0], 0);
    clear_all();

    // R4 wrap
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i));
    for (int i = 0; i < 3; i++) host_read(7'h7F, 8'hA0 + 8'(i), "R4 pre-wrap");
    for (int i = 0; i < 15; i++) push(8'hB0 + 8'(i));
    cpu_read(8'h40, 8'hBD, "R4 write wrapped to base");
    for (int i = 0; i < 15; i++) host_read(7'h7F, 8'hB0 + 8'(i), "R4 wrap order");
    check_eq("R4 level after wrap", fifo_level, 0);

    cyc();
    finish_run();
  end
endmodule